// File: doc/BRIEF.md
# Compact-Instruction Register ALU

This unit executes the data-processing group of a 16-bit compact instruction encoding. It covers the two-register form (bitwise AND and XOR, three register-amount shifts, add-with-carry and subtract-with-carry), the three-register add and the register-minus-small-immediate subtract. Each cycle it takes an instruction word and a valid strobe. It drives two read indices to an external register file and receives the two 32-bit operand values back in the same cycle. On the next clock edge it presents a registered result, destination index, write enable and the updated condition flags.

Every add and subtract goes through a single adder that computes `a + b' + cin`, where `b'` is the second operand, inverted for subtraction. Carry is taken from the 33rd sum bit and overflow from a sign comparison. This is why subtract-with-carry needs no separate borrow path: the held carry flag is the carry-in. The flags are `{N, Z, C, V}` in bits `[3:0]` of the flag output, with N in bit 3.

Top module: `cmp_alu`

## Requirements
- R1: An accepted instruction drives `dst_idx` from instruction bits [2:0]. The two-register form reads operand A from index bits [2:0] and operand B from bits [5:3]. The three-register add and the immediate subtract read A from bits [5:3] and B from bits [8:6].
- R2: On every accepted write, N equals result bit 31 and Z is 1 exactly when the result is all zeros.
- R3: Two-register opcode 0 yields A AND B and opcode 1 yields A XOR B. Both leave C and V unchanged.
- R4: For the shifts (opcodes 2, 3, 4), only bits [7:0] of operand B form the amount. An amount of zero returns A unchanged and leaves C unchanged. No shift changes V.
- R5: Opcode 2 (left shift): for amounts 1..31, C takes the last bit shifted out. An amount of 32 gives 0 with C = A[0]. Amounts above 32 give 0 with C = 0.
- R6: Opcode 3 (logical right shift): for amounts 1..31, C = A[n-1]. An amount of 32 gives 0 with C = A[31]. Amounts above 32 give 0 with C = 0.
- R7: Opcode 4 (arithmetic right shift) fills with A[31]. For amounts 1..31, C = A[n-1]. Amounts of 32 or more give 32 copies of A[31], with C = A[31].
- R8: Opcode 5 yields A + B + C. C is set to the unsigned carry out, and V to signed overflow.
- R9: Opcode 6 yields A - B - (1 - C). C is set to 1 exactly when no borrow occurs, and V to signed overflow.
- R10: An instruction matching `0x1800` under mask `0xFE00` yields A + B, with carry-in 0, and updates all four flags.
- R11: An instruction matching `0x1E00` under mask `0xFE00` yields A minus the zero-extended immediate in bits [8:6]. C is 1 when no borrow occurs, and V follows signed overflow.
- R12: Two-register opcodes 7..15, and any word outside the three recognised forms (two-register form: bits [15:10] = 6'b010000), raise `unsupported` for one cycle. Such a word suppresses the write and leaves the flags unchanged.
- R13: After reset, the result, write enable, unsupported and all flags read 0.
- R14: A cycle without `in_valid` deasserts the write enable and unsupported, and leaves the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Instruction word is valid this cycle |
| instr | input | 16 | Instruction word |
| src_a_idx | output | 3 | Register-file read index for operand A |
| src_b_idx | output | 3 | Register-file read index for operand B |
| op_a | input | 32 | Operand A value read at `src_a_idx` |
| op_b | input | 32 | Operand B value read at `src_b_idx` |
| result | output | 32 | Registered result |
| dst_idx | output | 3 | Registered destination index |
| wr_en | output | 1 | Registered write enable for `result` |
| unsupported | output | 1 | Registered flag for an unrecognised instruction |
| flags | output | 4 | Condition flags {N, Z, C, V} |

## Verification
The hardest states to reach are the subtract-with-carry cases that run with C = 0 and the shift amounts at or beyond the word width. The first needs a preceding instruction that has cleared carry. The second needs operand-B values whose low byte is 32 or more, or whose upper bits would wrongly change the amount if they were used. The stimulus chains instructions so that each one sets up the carry state the next one needs. It feeds shift amounts of 0x100, 32, 33, 40 and 200. An independent reference model computes every expected result and flag set using wide signed and unsigned arithmetic rather than an adder.

// File: rtl/cmp_alu_pkg.sv
`timescale 1ns/1ps
package cmp_alu_pkg;
    localparam int WORD_W  = 32;
    localparam int INSTR_W = 16;
    localparam int IDX_W   = 3;
    localparam int AMT_W   = 8;
    localparam int FLAG_W  = 4;

    // flag bit positions inside the flag word
    localparam int FN = 3;
    localparam int FZ = 2;
    localparam int FC = 1;
    localparam int FV = 0;

    typedef enum logic [3:0] {
        K_AND, K_EOR, K_LSL, K_LSR, K_ASR,
        K_ADC, K_SBC, K_ADD, K_SUBI, K_BAD
    } kind_e;

    typedef enum logic [1:0] {
        SH_LEFT, SH_RIGHT, SH_ARITH
    } shift_e;

    typedef struct packed {
        kind_e             kind;
        logic [IDX_W-1:0]  dst;
        logic [IDX_W-1:0]  src_a;
        logic [IDX_W-1:0]  src_b;
        logic [IDX_W-1:0]  imm;
    } dec_t;

    typedef struct packed {
        logic [WORD_W-1:0] res;
        logic [IDX_W-1:0]  dst;
        logic              wr;
        logic              undef;
        logic [FLAG_W-1:0] flags;
    } state_t;
endpackage

// File: rtl/cmp_decode.sv
`timescale 1ns/1ps
module cmp_decode
    import cmp_alu_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output dec_t               dec
);
    localparam logic [5:0] TWO_REG_TAG = 6'b010000;
    localparam logic [6:0] ADD3_TAG    = 7'b0001100;
    localparam logic [6:0] SUBI_TAG    = 7'b0001111;

    logic       is_two_reg;
    logic       is_add3;
    logic       is_subi;
    logic [3:0] opf;

    always_comb begin
        is_two_reg = (instr[15:10] == TWO_REG_TAG);
        is_add3    = (instr[15:9]  == ADD3_TAG);
        is_subi    = (instr[15:9]  == SUBI_TAG);
        opf        = instr[9:6];

        dec.dst = instr[2:0];
        dec.imm = instr[8:6];
        if (is_two_reg) begin
            dec.src_a = instr[2:0];
            dec.src_b = instr[5:3];
        end else begin
            dec.src_a = instr[5:3];
            dec.src_b = instr[8:6];
        end

        dec.kind = K_BAD;
        if (is_two_reg) begin
            case (opf)
                4'd0:    dec.kind = K_AND;
                4'd1:    dec.kind = K_EOR;
                4'd2:    dec.kind = K_LSL;
                4'd3:    dec.kind = K_LSR;
                4'd4:    dec.kind = K_ASR;
                4'd5:    dec.kind = K_ADC;
                4'd6:    dec.kind = K_SBC;
                default: dec.kind = K_BAD;
            endcase
        end else if (is_add3) begin
            dec.kind = K_ADD;
        end else if (is_subi) begin
            dec.kind = K_SUBI;
        end
    end
endmodule

// File: rtl/cmp_shift.sv
`timescale 1ns/1ps
module cmp_shift
    import cmp_alu_pkg::*;
#(
    parameter int W = WORD_W,
    parameter int A = AMT_W
) (
    input  logic [W-1:0] val,
    input  logic [A-1:0] amt,
    input  shift_e       mode,
    input  logic         c_in,
    output logic [W-1:0] out,
    output logic         c_out
);
    localparam int WIDE = 2 * W;

    logic [WIDE-1:0]        up;
    logic [WIDE-1:0]        dn;
    logic signed [WIDE-1:0] sdn;

    always_comb begin
        up  = {{W{1'b0}}, val} << amt;
        dn  = {val, {W{1'b0}}} >> amt;
        sdn = $signed({val, {W{1'b0}}}) >>> amt;

        out   = val;
        c_out = c_in;
        if (amt != '0) begin
            case (mode)
                SH_LEFT: begin
                    out   = up[W-1:0];
                    c_out = up[W];
                end
                SH_RIGHT: begin
                    out   = dn[WIDE-1:W];
                    c_out = dn[W-1];
                end
                default: begin
                    out   = sdn[WIDE-1:W];
                    c_out = sdn[W-1];
                end
            endcase
        end
    end

    always_comb begin
        if (amt == '0) begin
            AST_ZERO_AMOUNT_PASS: assert (out == val && c_out == c_in); // R4
        end
    end
endmodule

// File: rtl/cmp_adder.sv
`timescale 1ns/1ps
module cmp_adder
    import cmp_alu_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         invert_b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         ovf
);
    logic [W-1:0] b_eff;
    logic [W:0]   full;

    always_comb begin
        b_eff = invert_b ? ~b : b;
        full  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, cin};
        sum   = full[W-1:0];
        cout  = full[W];
        ovf   = (a[W-1] == b_eff[W-1]) && (full[W-1] != a[W-1]);
    end

    always_comb begin
        if (!invert_b && !cin) begin
            AST_CARRY_WRAPS: assert (cout == (sum < a)); // R10
        end
    end
endmodule

// File: rtl/cmp_alu.sv
`timescale 1ns/1ps
module cmp_alu
    import cmp_alu_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [INSTR_W-1:0] instr,
    output logic [IDX_W-1:0]   src_a_idx,
    output logic [IDX_W-1:0]   src_b_idx,
    input  logic [W-1:0]       op_a,
    input  logic [W-1:0]       op_b,
    output logic [W-1:0]       result,
    output logic [IDX_W-1:0]   dst_idx,
    output logic               wr_en,
    output logic               unsupported,
    output logic [FLAG_W-1:0]  flags
);
    dec_t         dec;
    state_t       st_d, st_q;

    shift_e       sh_mode;
    logic [W-1:0] sh_out;
    logic         sh_c;

    logic [W-1:0] add_b;
    logic         add_inv;
    logic         add_cin;
    logic [W-1:0] add_sum;
    logic         add_c;
    logic         add_v;

    cmp_decode u_dec (
        .instr (instr),
        .dec   (dec)
    );

    assign src_a_idx = dec.src_a;
    assign src_b_idx = dec.src_b;

    always_comb begin
        case (dec.kind)
            K_LSL:   sh_mode = SH_LEFT;
            K_LSR:   sh_mode = SH_RIGHT;
            default: sh_mode = SH_ARITH;
        endcase
    end

    cmp_shift #(.W(W), .A(AMT_W)) u_shift (
        .val   (op_a),
        .amt   (op_b[AMT_W-1:0]),
        .mode  (sh_mode),
        .c_in  (st_q.flags[FC]),
        .out   (sh_out),
        .c_out (sh_c)
    );

    // operand B and carry-in selection for the shared adder
    always_comb begin
        add_b   = op_b;
        add_inv = 1'b0;
        add_cin = 1'b0;
        case (dec.kind)
            K_ADC: add_cin = st_q.flags[FC];
            K_SBC: begin
                add_inv = 1'b1;
                add_cin = st_q.flags[FC];
            end
            K_SUBI: begin
                add_b   = {{(W-IDX_W){1'b0}}, dec.imm};
                add_inv = 1'b1;
                add_cin = 1'b1;
            end
            default: ;
        endcase
    end

    cmp_adder #(.W(W)) u_add (
        .a        (op_a),
        .b        (add_b),
        .invert_b (add_inv),
        .cin      (add_cin),
        .sum      (add_sum),
        .cout     (add_c),
        .ovf      (add_v)
    );

    always_comb begin
        logic [W-1:0] r;
        logic         set_cv;
        logic         set_c_only;

        st_d       = st_q;
        st_d.wr    = 1'b0;
        st_d.undef = 1'b0;
        r          = '0;
        set_cv     = 1'b0;
        set_c_only = 1'b0;

        if (in_valid) begin
            case (dec.kind)
                K_AND: r = op_a & op_b;
                K_EOR: r = op_a ^ op_b;
                K_LSL, K_LSR, K_ASR: begin
                    r          = sh_out;
                    set_c_only = 1'b1;
                end
                K_ADC, K_SBC, K_ADD, K_SUBI: begin
                    r      = add_sum;
                    set_cv = 1'b1;
                end
                default: ;
            endcase

            if (dec.kind == K_BAD) begin
                st_d.undef = 1'b1;
            end else begin
                st_d.res       = r;
                st_d.dst       = dec.dst;
                st_d.wr        = 1'b1;
                st_d.flags[FN] = r[W-1];
                st_d.flags[FZ] = (r == '0);
                if (set_c_only) begin
                    st_d.flags[FC] = sh_c;
                end
                if (set_cv) begin
                    st_d.flags[FC] = add_c;
                    st_d.flags[FV] = add_v;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign result      = st_q.res;
    assign dst_idx     = st_q.dst;
    assign wr_en       = st_q.wr;
    assign unsupported = st_q.undef;
    assign flags       = st_q.flags;

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!wr_en && !unsupported && $stable(flags))); // R14

    AST_UNDEF_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && dec.kind == K_BAD) |=> (!wr_en && unsupported && $stable(flags))); // R12

    AST_LOGIC_KEEPS_CV: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (dec.kind == K_AND || dec.kind == K_EOR))
        |=> (flags[FC:FV] == $past(flags[FC:FV]))); // R3

    AST_SHIFT_KEEPS_V: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (dec.kind == K_LSL || dec.kind == K_LSR || dec.kind == K_ASR))
        |=> (flags[FV] == $past(flags[FV]))); // R4

    AST_NZ_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (flags[FZ] == (result == '0) && flags[FN] == result[W-1])); // R2

    AST_WRITE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && unsupported)); // R12
endmodule

// File: tb/cmp_alu_tb.sv
`timescale 1ns/1ps
module cmp_alu_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] instr = '0;
    logic [2:0]  src_a_idx, src_b_idx;
    logic [31:0] op_a, op_b;
    logic [31:0] result;
    logic [2:0]  dst_idx;
    logic        wr_en, unsupported;
    logic [3:0]  flags;

    logic [31:0] regs [8];

    int  n_chk = 0;
    int  n_err = 0;
    bit  done  = 0;
    logic [3:0] mflags = '0;

    typedef struct {
        logic [31:0] res;
        logic [2:0]  dst;
        logic        wr;
        logic        undef;
        logic [3:0]  fl;
        bit          full;
        string       tag;
    } exp_t;

    exp_t sb[$];

    always #2 clk = ~clk;

    assign op_a = regs[src_a_idx];
    assign op_b = regs[src_b_idx];

    cmp_alu u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .instr       (instr),
        .src_a_idx   (src_a_idx),
        .src_b_idx   (src_b_idx),
        .op_a        (op_a),
        .op_b        (op_b),
        .result      (result),
        .dst_idx     (dst_idx),
        .wr_en       (wr_en),
        .unsupported (unsupported),
        .flags       (flags)
    );

    function automatic logic ovf_of(input longint exact);
        return (exact > 64'sd2147483647) || (exact < -64'sd2147483648);
    endfunction

    // reference model written from the requirements
    function automatic exp_t model(input logic [15:0] w, input logic [31:0] a,
                                   input logic [31:0] b, input logic [3:0] f);
        exp_t   e;
        int     n;
        longint sa, sb2, ex;
        logic [63:0] ua;
        logic [31:0] r;
        logic   c, v;
        bit     ok;
        e.fl = f; e.wr = 0; e.undef = 0; e.full = 1; e.dst = w[2:0]; e.res = '0; e.tag = "";
        c = f[1]; v = f[0]; r = '0; ok = 1;
        sa  = longint'($signed(a));
        sb2 = longint'($signed(b));
        n   = int'(b[7:0]);
        if (w[15:10] == 6'b010000) begin
            case (w[9:6])
                4'd0: r = a & b;
                4'd1: r = a ^ b;
                4'd2: if (n == 0) r = a;
                      else if (n < 32) begin r = a << n; c = a[32-n]; end
                      else if (n == 32) begin r = 0; c = a[0]; end
                      else begin r = 0; c = 0; end
                4'd3: if (n == 0) r = a;
                      else if (n < 32) begin r = a >> n; c = a[n-1]; end
                      else if (n == 32) begin r = 0; c = a[31]; end
                      else begin r = 0; c = 0; end
                4'd4: if (n == 0) r = a;
                      else if (n < 32) begin r = 32'($signed(a) >>> n); c = a[n-1]; end
                      else begin r = {32{a[31]}}; c = a[31]; end
                4'd5: begin
                    ua = {32'b0, a} + {32'b0, b} + {63'b0, f[1]};
                    r = ua[31:0]; c = ua[32];
                    ex = sa + sb2 + longint'(f[1]); v = ovf_of(ex);
                end
                4'd6: begin
                    ua = {32'b0, a} - {32'b0, b} - {63'b0, ~f[1]};
                    r = ua[31:0];
                    c = ({32'b0, a} >= ({32'b0, b} + {63'b0, ~f[1]}));
                    ex = sa - sb2 - longint'(~f[1]); v = ovf_of(ex);
                end
                default: ok = 0;
            endcase
        end else if (w[15:9] == 7'b0001100) begin
            ua = {32'b0, a} + {32'b0, b};
            r = ua[31:0]; c = ua[32];
            v = ovf_of(sa + sb2);
        end else if (w[15:9] == 7'b0001111) begin
            r = a - {29'b0, w[8:6]};
            c = (a >= {29'b0, w[8:6]});
            v = ovf_of(sa - longint'(w[8:6]));
        end else begin
            ok = 0;
        end
        if (ok) begin
            e.wr = 1; e.res = r;
            e.fl = {r[31], (r == 0), c, v};
        end else begin
            e.undef = 1; e.full = 0;
        end
        return e;
    endfunction

    task automatic issue(input logic [15:0] w, input logic [31:0] va,
                         input logic [31:0] vb, input string tag);
        exp_t e;
        @(negedge clk);
        if (w[15:10] == 6'b010000) begin
            regs[w[2:0]] = va; regs[w[5:3]] = vb;
        end else begin
            regs[w[5:3]] = va; regs[w[8:6]] = vb;
        end
        instr    = w;
        in_valid = 1'b1;
        e = model(w, va, vb, mflags);
        e.tag = tag;
        mflags = e.fl;
        sb.push_back(e);
    endtask

    task automatic idle(input string tag);
        exp_t e;
        @(negedge clk);
        in_valid = 1'b0;
        instr    = 16'h4000;
        e.res = '0; e.dst = '0; e.wr = 0; e.undef = 0; e.fl = mflags; e.full = 0; e.tag = tag;
        sb.push_back(e);
    endtask

    function automatic logic [15:0] two(input int op, input int rs, input int rd);
        return 16'h4000 | 16'(op << 6) | 16'(rs << 3) | 16'(rd);
    endfunction

    // scoreboard monitor
    always @(posedge clk) begin
        exp_t e;
        #1;
        if (sb.size() > 0) begin
            e = sb.pop_front();
            n_chk++;
            if (wr_en !== e.wr || unsupported !== e.undef || flags !== e.fl ||
                (e.full && (result !== e.res || dst_idx !== e.dst))) begin
                n_err++;
                $display("FAIL %s: got res=%h dst=%0d wr=%b undef=%b fl=%b exp res=%h dst=%0d wr=%b undef=%b fl=%b",
                         e.tag, result, dst_idx, wr_en, unsupported, flags,
                         e.res, e.dst, e.wr, e.undef, e.fl);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog: got running, exp finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) regs[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        n_chk++;
        if (result !== '0 || wr_en !== 0 || unsupported !== 0 || flags !== 4'b0) begin
            n_err++;
            $display("FAIL R13: got res=%h wr=%b undef=%b fl=%b exp all zero",
                     result, wr_en, unsupported, flags);
        end

        issue(two(0, 1, 2), 32'hF0F0_00FF, 32'h0F0F_00FF, "R3 and, R1 dst");
        issue(two(1, 3, 5), 32'hF0F0_0000, 32'h0F0F_0000, "R3 eor, R2 N");
        issue(16'h1800 | (3'd5 << 6) | (3'd4 << 3) | 3'd1, 32'hFFFF_FFFF, 32'h1, "R10 add carry, R2 Z");
        issue(two(0, 1, 0), 32'hFFFF_FFFF, 32'h0, "R3 and keeps C, R2 Z");
        issue(two(5, 6, 7), 32'h7FFF_FFFF, 32'h0, "R8 adc with C=1 overflow");
        issue(two(6, 3, 4), 32'h5, 32'h3, "R9 sbc with C=0");
        issue(two(6, 3, 4), 32'h3, 32'h5, "R9 sbc with C=1 borrow");
        issue(two(5, 1, 0), 32'h8000_0000, 32'h8000_0000, "R8 adc C=0 neg overflow");
        issue(16'h1E00 | (3'd1 << 6) | (3'd2 << 3) | 3'd6, 32'h1, 32'h0, "R11 subi to zero");
        issue(16'h1E00 | (3'd7 << 6) | (3'd2 << 3) | 3'd6, 32'h0, 32'h0, "R11 subi borrow");
        issue(16'h1E00 | (3'd1 << 6) | (3'd2 << 3) | 3'd3, 32'h8000_0000, 32'h0, "R11 subi overflow");
        issue(two(2, 1, 0), 32'h1234_5678, 32'h0000_0100, "R4 low byte zero keeps C");
        issue(two(2, 1, 0), 32'h8000_0001, 32'd1, "R5 lsl 1");
        issue(two(2, 1, 0), 32'h0000_0001, 32'd32, "R5 lsl 32");
        issue(two(2, 1, 0), 32'hFFFF_FFFF, 32'd33, "R5 lsl 33");
        issue(two(3, 1, 0), 32'h8000_0018, 32'h0000_FF04, "R6 lsr 4, R4 byte");
        issue(two(3, 1, 0), 32'h8000_0000, 32'd32, "R6 lsr 32");
        issue(two(3, 1, 0), 32'hFFFF_FFFF, 32'd40, "R6 lsr 40");
        issue(two(4, 1, 0), 32'h8000_0000, 32'd4, "R7 asr 4");
        issue(two(4, 1, 0), 32'h8000_0000, 32'd200, "R7 asr 200");
        issue(two(4, 1, 0), 32'h7FFF_FFFF, 32'd33, "R7 asr 33 positive");
        issue(two(4, 1, 0), 32'h4000_0003, 32'd1, "R7 asr 1");
        issue(two(7, 1, 0), 32'h1, 32'h1, "R12 opcode 7");
        issue(two(15, 1, 0), 32'h1, 32'h1, "R12 opcode 15");
        issue(16'h0000, 32'h1, 32'h1, "R12 other form");
        idle("R14 idle");
        idle("R14 idle again");
        issue(two(1, 2, 3), 32'h0, 32'h0, "R2 eor zero, R1");

        idle("drain");
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule